// File: doc/BRIEF.md
# Cascadable Binary Line Decoder (3-to-8 slice, 4-to-16 pair)

The block turns a binary address into a one-hot, active-low line select. Its basic unit is a slice that decodes three address bits onto eight outputs. A slice decodes only while its enable is asserted. Its enable is formed from three terms of mixed polarity: one active-high term and two active-low terms. Because of this mix, a slice can be gated by a true or by an inverted copy of a higher address bit without any extra gate.

The top level joins two slices into a sixteen-line decoder. Address bit 3 acts as the slice select. The lower slice takes that bit on an active-low enable, and the upper slice takes it on its active-high enable. A global active-low enable of the top level drives the remaining active-low enable of both slices. Negating it therefore blanks all sixteen lines. There is no clock anywhere in the block: every output follows its inputs combinationally.

Top module: `dec_cascade`

## Requirements
- R1: A slice decodes only when its active-high enable is 1 and both of its active-low enables are 0. Any other combination of the three enables counts as disabled.
- R2: While enabled, slice output bit i (of y_n_o[7:0]) is 0 exactly when addr_i equals i. addr_i[2] is the most significant address bit and addr_i[0] the least significant.
- R3: A disabled slice drives all eight outputs to 1.
- R4: At no input combination does a slice drive more than one output to 0.
- R5: With en_n_i = 0, the top level drives y_n_o[addr_i] to 0. addr_i[3] = 0 selects lines 0 to 7 (lower slice) and addr_i[3] = 1 selects lines 8 to 15 (upper slice).
- R6: With en_n_i = 1, all sixteen top-level outputs are 1, for every address.
- R7: At the top level at most one of the sixteen outputs is 0, so at most one slice is active in any decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 4 | Binary line address; bit 3 picks the slice |
| en_n_i | input | 1 | Global enable, active low |
| y_n_o | output | 16 | Decoded lines, active low, one-hot when enabled |

## Verification
The mixed-polarity enable of a single slice cannot be reached fully from the top-level ports. In the pair, the lower slice has its active-high term tied to 1, and the upper slice has one active-low term tied to 0. Because of that, the bench also instantiates one slice on its own. It walks all eight enable patterns across all eight addresses, so each single-term failure of the enable shows up at the outputs. The pair is then swept over every address with both global enable levels, including the 7-to-8 step, where decoding crosses from one slice to the other.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int SLICE_AW = 3;
  localparam int SLICE_OW = 1 << SLICE_AW;
  localparam int SLICE_HI = 1;
  localparam int SLICE_LO = 2;
  typedef logic [SLICE_OW-1:0] slice_lines_t;
endpackage

// File: rtl/dec_enable_gate.sv
module dec_enable_gate #(
  parameter int NUM_HI = 1,
  parameter int NUM_LO = 2
) (
  input  logic [NUM_HI-1:0] hi_i,
  input  logic [NUM_LO-1:0] lo_n_i,
  output logic              en_o
);
  // All true-sense terms high and all inverted terms low.
  always_comb begin
    en_o = (&hi_i) & ~(|lo_n_i);
  end
endmodule

// File: rtl/dec_line_array.sv
module dec_line_array #(
  parameter int AW = 3,
  localparam int OW = 1 << AW
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic [OW-1:0] y_n_o
);
  // One comparator per output line: low only for the matching minterm.
  for (genvar g = 0; g < OW; g++) begin : g_line
    assign y_n_o[g] = ~(en_i & (addr_i == AW'(g)));
  end
endmodule

// File: rtl/dec_slice.sv
module dec_slice
  import dec_pkg::*;
(
  input  logic [SLICE_AW-1:0] addr_i,
  input  logic                en_hi_i,
  input  logic                en_lo_a_n_i,
  input  logic                en_lo_b_n_i,
  output slice_lines_t        y_n_o
);
  logic slice_en;

  dec_enable_gate #(
    .NUM_HI (SLICE_HI),
    .NUM_LO (SLICE_LO)
  ) u_gate (
    .hi_i   (en_hi_i),
    .lo_n_i ({en_lo_b_n_i, en_lo_a_n_i}),
    .en_o   (slice_en)
  );

  dec_line_array #(
    .AW (SLICE_AW)
  ) u_lines (
    .addr_i (addr_i),
    .en_i   (slice_en),
    .y_n_o  (y_n_o)
  );
endmodule

// File: rtl/dec_cascade.sv
module dec_cascade
  import dec_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int OUT_W = 1 << ADDR_W,
  localparam int UPPER_W = ADDR_W - SLICE_AW,
  localparam int NUM_SLICES = 1 << UPPER_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_n_i,
  output logic [OUT_W-1:0]  y_n_o
);
  logic [UPPER_W-1:0]  upper;
  logic [SLICE_AW-1:0] lower;

  assign upper = addr_i[ADDR_W-1:SLICE_AW];
  assign lower = addr_i[SLICE_AW-1:0];

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic sel_hi;
    logic sel_lo_n;

    if (NUM_SLICES == 2) begin : g_pair
      // Two slices: the select bit feeds opposite-polarity enables.
      if (s == 0) begin : g_low
        assign sel_hi   = 1'b1;
        assign sel_lo_n = upper[0];
      end else begin : g_high
        assign sel_hi   = upper[0];
        assign sel_lo_n = 1'b0;
      end
    end else begin : g_multi
      assign sel_hi   = (upper == UPPER_W'(s));
      assign sel_lo_n = 1'b0;
    end

    dec_slice u_slice (
      .addr_i      (lower),
      .en_hi_i     (sel_hi),
      .en_lo_a_n_i (sel_lo_n),
      .en_lo_b_n_i (en_n_i),
      .y_n_o       (y_n_o[s*SLICE_OW +: SLICE_OW])
    );
  end
endmodule

// File: rtl/dec_cascade_chk.sv
module dec_cascade_chk #(
  parameter int ADDR_W = 4,
  localparam int OUT_W = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              en_n_i,
  input logic [OUT_W-1:0]  y_n_o
);
  always_comb begin
    if (!$isunknown({addr_i, en_n_i, y_n_o})) begin
      a_r6_off_all_high: assert (!en_n_i || (&y_n_o));
      a_r7_at_most_one_low: assert ($onehot0(~y_n_o));
      a_r5_addressed_line_low: assert (en_n_i || !y_n_o[addr_i]);
    end
  end
endmodule

module dec_slice_chk (
  input logic [2:0] addr_i,
  input logic       en_hi_i,
  input logic       en_lo_a_n_i,
  input logic       en_lo_b_n_i,
  input logic [7:0] y_n_o
);
  logic on;
  assign on = en_hi_i && !en_lo_a_n_i && !en_lo_b_n_i;

  always_comb begin
    if (!$isunknown({addr_i, en_hi_i, en_lo_a_n_i, en_lo_b_n_i, y_n_o})) begin
      a_r1_off_term_blanks: assert (on || (&y_n_o));
      a_r3_disabled_high: assert (!en_hi_i ? (&y_n_o) : 1'b1);
      a_r4_slice_onehot: assert ($onehot0(~y_n_o));
      a_r2_match_low: assert (!on || !y_n_o[addr_i]);
    end
  end
endmodule

bind dec_cascade dec_cascade_chk #(.ADDR_W(ADDR_W)) u_chk (
  .addr_i (addr_i),
  .en_n_i (en_n_i),
  .y_n_o  (y_n_o)
);

bind dec_slice dec_slice_chk u_slice_chk (
  .addr_i      (addr_i),
  .en_hi_i     (en_hi_i),
  .en_lo_a_n_i (en_lo_a_n_i),
  .en_lo_b_n_i (en_lo_b_n_i),
  .y_n_o       (y_n_o)
);

// File: tb/dec_cascade_tb_top.sv
`timescale 1ns/1ps
module dec_cascade_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [3:0]  addr;
  logic        en_n;
  logic [15:0] y_n;

  logic [2:0]  s_addr;
  logic        s_hi, s_lo_a_n, s_lo_b_n;
  logic [7:0]  s_y_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dec_cascade dut_i (.addr_i(addr), .en_n_i(en_n), .y_n_o(y_n));

  dec_slice slice_i (
    .addr_i(s_addr), .en_hi_i(s_hi), .en_lo_a_n_i(s_lo_a_n),
    .en_lo_b_n_i(s_lo_b_n), .y_n_o(s_y_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    addr = '0; en_n = 1'b1;
    s_addr = '0; s_hi = 1'b0; s_lo_a_n = 1'b1; s_lo_b_n = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: initial, disabled state of the pair
    check("R6 initial", y_n, 16'hFFFF);
    // R3: initial, disabled state of the standalone slice
    check("R3 initial", {8'h00, s_y_n}, 16'h00FF);

    // Standalone slice: every enable pattern against every address (R1, R2, R3, R4)
    for (int e = 0; e < 8; e++) begin
      for (int a = 0; a < 8; a++) begin
        @(posedge clk);
        s_hi = e[0]; s_lo_a_n = e[1]; s_lo_b_n = e[2];
        s_addr = 3'(a);
        @(negedge clk);
        begin
          logic [7:0] exp8;
          bit on;
          on = (e == 1);
          exp8 = 8'hFF;
          if (on) exp8[a] = 1'b0;
          if (on) check("R2 slice decode", {8'h00, s_y_n}, {8'h00, exp8});
          else if (e[0] == 0) check("R3 slice disabled", {8'h00, s_y_n}, 16'h00FF);
          else check("R1 slice low-term negated", {8'h00, s_y_n}, 16'h00FF);
          check("R4 slice low count", 16'($countones(~s_y_n) <= 1), 16'd1);
        end
      end
    end

    // Pair: both global enable levels over all addresses (R5, R6, R7)
    for (int g = 0; g < 2; g++) begin
      for (int a = 0; a < 16; a++) begin
        @(posedge clk);
        en_n = g[0];
        addr = 4'(a);
        @(negedge clk);
        begin
          logic [15:0] exp16;
          exp16 = 16'hFFFF;
          if (g == 0) exp16[a] = 1'b0;
          if (g == 0) check("R5 pair decode", y_n, exp16);
          else check("R6 pair disabled", y_n, 16'hFFFF);
          check("R7 pair low count", 16'($countones(~y_n) <= 1), 16'd1);
          if (g == 0) begin
            // R7: the inactive slice stays fully high
            if (a < 8) check("R7 upper idle", {8'h00, y_n[15:8]}, 16'h00FF);
            else       check("R7 lower idle", {8'h00, y_n[7:0]}, 16'h00FF);
          end
        end
      end
    end

    finish_run();
  end
endmodule